// File: doc/BRIEF.md
# Double-Buffered Text VRAM Copy Engine

This block sits between a CPU bus and two text-mode video RAMs. The CPU writes a back buffer through a fixed memory window, and the display reads a separate front buffer. When vertical blanking begins, the block copies the whole back buffer into the front buffer, one byte per clock. A single shared counter addresses both RAMs, so the display never shows a frame that is only partly updated.

Two memory-mapped registers sit just above the window. Software uses them to avoid losing writes. The status byte raises its busy bit a configurable number of scanlines before blanking, so a CPU that polls it just before a copy still has time to finish its store. The control byte lets software suspend copying altogether while it does a bulk update of the back buffer.

The window holds 4800 bytes: 2400 character codes followed by 2400 attribute bytes. Both RAMs are external and read combinationally, and this block drives only their address, data and enable lines.

Top module: `vdb_copy_engine`

## Requirements
- R1: A CPU write with bus_mreq_n and bus_wr_n both low and an address in 0x8000..0x92BF asserts back_we in that cycle. back_addr equals the address minus 0x8000 and back_wdata equals bus_wdata.
- R2: A write with bus_mreq_n high, or one addressed outside the window (for example 0x7FFF, or the status byte at 0x92C0), never asserts back_we.
- R3: If copying is enabled, a rising edge on vblank, seen at a clock edge, raises copy_in_progress from the next cycle on. It stays high for exactly 4800 cycles. In the k-th of those cycles (k from 0), front_we is high, front_addr and back_addr equal k, and front_wdata equals the back-buffer byte at k.
- R4: CPU writes to the window while copy_in_progress is high are dropped, and the back buffer keeps its old byte.
- R5: A read of 0x92C0 returns 0x01 when scanline is in [480-4, 480) or a copy is running, and 0x00 otherwise.
- R6: Writing 0x00 to 0x92C1 disables copying, and a vblank rise then starts no copy. Any nonzero value written there re-enables copying.
- R7: After reset copying is enabled. A read of 0x92C1 returns 0x01 when enabled and 0x00 when disabled.
- R8: A copy that has started runs all 4800 cycles even if 0x92C1 is written with 0x00 while it runs.
- R9: A read (bus_mreq_n and bus_rd_n low) inside the window returns the back-buffer byte at that offset. During a copy such a read returns 0x00.
- R10: Outside a copy, front_addr follows disp_addr and front_rd_en is high. During a copy, front_rd_en is low.
- R11: While reset is asserted and right after it, copy_in_progress, front_we and back_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data, 0 when not reading |
| bus_mreq_n | input | 1 | Memory request, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| vblank | input | 1 | Vertical blanking flag from the timing generator |
| scanline | input | 10 | Current scanline number |
| disp_addr | input | 13 | Display read address for the front buffer |
| copy_in_progress | output | 1 | High while the buffer copy runs |
| back_addr | output | 13 | Back RAM address |
| back_wdata | output | 8 | Back RAM write data |
| back_we | output | 1 | Back RAM write enable |
| back_rdata | input | 8 | Back RAM read data (combinational) |
| front_addr | output | 13 | Front RAM address |
| front_wdata | output | 8 | Front RAM write data |
| front_we | output | 1 | Front RAM write enable |
| front_rd_en | output | 1 | Display may read the front RAM |

## Verification
A wrong copy counter shows up in the very next cycle, because front_addr or front_wdata no longer matches the byte the reference expects. It also shows up at the end of the copy as a run length other than 4800 and a front buffer that differs from the back buffer. A stale or wrong enable bit first shows at the next vblank rise, as a copy that starts or fails to start, and on any read of 0x92C1. A wrong busy window or a leak of CPU writes during the copy is caught in the same cycle as the read or the write enable. After that, the R4 readback exposes the corrupted byte.

// File: rtl/vdb_pkg.sv
package vdb_pkg;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_VRAM   = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_CTRL   = 2'd3
   } bus_sel_e;

   typedef struct packed {
      bus_sel_e sel;
      logic     wr_act;
      logic     rd_act;
   } bus_dec_t;

endpackage

// File: rtl/vdb_bus_decode.sv
module vdb_bus_decode
   import vdb_pkg::*;
#(
   parameter int AW        = 16,
   parameter int VAW       = 13,
   parameter int WIN_BASE  = 'h8000,
   parameter int WIN_BYTES = 4800
) (
   input  logic [AW-1:0]  bus_addr,
   input  logic           bus_mreq_n,
   input  logic           bus_wr_n,
   input  logic           bus_rd_n,
   output bus_dec_t       dec,
   output logic [VAW-1:0] vram_off
);
   localparam logic [AW-1:0] WIN_LO    = AW'(WIN_BASE);
   localparam logic [AW-1:0] WIN_HI    = AW'(WIN_BASE + WIN_BYTES);
   localparam logic [AW-1:0] STAT_ADDR = WIN_HI;
   localparam logic [AW-1:0] CTRL_ADDR = AW'(WIN_BASE + WIN_BYTES + 1);

   logic [AW-1:0] diff;

   if (WIN_BASE + WIN_BYTES + 1 >= (1 << AW)) begin : g_bad_win
      $error("register bytes fall outside the address space");
   end
   if (WIN_BYTES > (1 << VAW)) begin : g_bad_vaw
      $error("window larger than the VRAM address range");
   end

   always_comb begin
      diff         = bus_addr - WIN_LO;
      vram_off     = diff[VAW-1:0];
      dec.wr_act   = !bus_mreq_n && !bus_wr_n;
      dec.rd_act   = !bus_mreq_n && !bus_rd_n;
      if (bus_addr >= WIN_LO && bus_addr < WIN_HI) begin
         dec.sel = SEL_VRAM;
      end else if (bus_addr == STAT_ADDR) begin
         dec.sel = SEL_STATUS;
      end else if (bus_addr == CTRL_ADDR) begin
         dec.sel = SEL_CTRL;
      end else begin
         dec.sel = SEL_NONE;
      end
   end

endmodule

// File: rtl/vdb_ctrl_regs.sv
module vdb_ctrl_regs #(
   parameter int DW          = 8,
   parameter int LW          = 10,
   parameter int VBLANK_LINE = 480,
   parameter int LEAD_LINES  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_wr,
   input  logic [DW-1:0] wdata,
   input  logic [LW-1:0] scanline,
   input  logic          copying,
   output logic          copy_en,
   output logic          busy
);
   logic early;

   if (LEAD_LINES > VBLANK_LINE) begin : g_bad_lead
      $error("lead window longer than the active area");
   end
   if (VBLANK_LINE >= (1 << LW)) begin : g_bad_lw
      $error("scanline width too small for the blanking line");
   end

   if (LEAD_LINES == 0) begin : g_no_lead
      assign early = 1'b0;
   end else begin : g_lead
      localparam logic [LW-1:0] LEAD_LO = LW'(VBLANK_LINE - LEAD_LINES);
      localparam logic [LW-1:0] LEAD_HI = LW'(VBLANK_LINE);
      assign early = (scanline >= LEAD_LO) && (scanline < LEAD_HI);
   end

   assign busy = early || copying;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         copy_en <= 1'b1;
      end else if (ctrl_wr) begin
         copy_en <= |wdata;
      end
   end

   AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (copy_en == ($past(wdata) != '0))); // R6

   AST_BUSY_IN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      copying |-> busy); // R5

endmodule

// File: rtl/vdb_copy_seq.sv
module vdb_copy_seq #(
   parameter int VAW      = 13,
   parameter int COPY_LEN = 4800
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           vblank,
   input  logic           copy_en,
   output logic           copying,
   output logic [VAW-1:0] cnt
);
   localparam logic [VAW-1:0] LAST = VAW'(COPY_LEN - 1);

   logic vblank_q;
   logic start;
   logic last;

   if (COPY_LEN < 2 || COPY_LEN > (1 << VAW)) begin : g_bad_len
      $error("copy length does not fit the counter");
   end

   assign last  = (cnt == LAST);
   assign start = vblank && !vblank_q && copy_en && !copying;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vblank_q <= 1'b0;
         copying  <= 1'b0;
         cnt      <= '0;
      end else begin
         vblank_q <= vblank;
         if (copying) begin
            if (last) begin
               copying <= 1'b0;
               cnt     <= '0;
            end else begin
               cnt <= cnt + VAW'(1);
            end
         end else if (start) begin
            copying <= 1'b1;
            cnt     <= '0;
         end
      end
   end

   AST_COPY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (copying && !last) |=> copying); // R8

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (copying && !last) |=> (cnt == $past(cnt) + VAW'(1))); // R3

   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(copying) |-> (cnt == '0)); // R3

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(copying) |-> $past(copy_en)); // R6

endmodule

// File: rtl/vdb_ram_mux.sv
module vdb_ram_mux #(
   parameter int DW  = 8,
   parameter int VAW = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           copying,
   input  logic [VAW-1:0] cnt,
   input  logic [VAW-1:0] cpu_off,
   input  logic           cpu_vram_wr,
   input  logic [DW-1:0]  cpu_wdata,
   input  logic [DW-1:0]  back_rdata,
   input  logic [VAW-1:0] disp_addr,
   output logic [VAW-1:0] back_addr,
   output logic [DW-1:0]  back_wdata,
   output logic           back_we,
   output logic [VAW-1:0] front_addr,
   output logic [DW-1:0]  front_wdata,
   output logic           front_we,
   output logic           front_rd_en
);
   always_comb begin
      back_addr   = copying ? cnt : cpu_off;
      back_wdata  = cpu_wdata;
      back_we     = cpu_vram_wr && !copying;
      front_addr  = copying ? cnt : disp_addr;
      front_wdata = back_rdata;
      front_we    = copying;
      front_rd_en = !copying;
   end

   AST_NO_CPU_WR_IN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      front_we |-> !back_we); // R4

   AST_FRONT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      front_we |-> !front_rd_en); // R10

   AST_SHARED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      front_we |-> (front_addr == back_addr)); // R3

endmodule

// File: rtl/vdb_copy_engine.sv
module vdb_copy_engine
   import vdb_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter int LW          = 10,
   parameter int WIN_BASE    = 'h8000,
   parameter int CELLS       = 2400,
   parameter int VBLANK_LINE = 480,
   parameter int LEAD_LINES  = 4,
   localparam int WIN_BYTES  = 2 * CELLS,
   localparam int VAW        = $clog2(WIN_BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   input  logic           bus_mreq_n,
   input  logic           bus_wr_n,
   input  logic           bus_rd_n,
   input  logic           vblank,
   input  logic [LW-1:0]  scanline,
   input  logic [VAW-1:0] disp_addr,
   output logic           copy_in_progress,
   output logic [VAW-1:0] back_addr,
   output logic [DW-1:0]  back_wdata,
   output logic           back_we,
   input  logic [DW-1:0]  back_rdata,
   output logic [VAW-1:0] front_addr,
   output logic [DW-1:0]  front_wdata,
   output logic           front_we,
   output logic           front_rd_en
);
   bus_dec_t       dec;
   logic [VAW-1:0] cpu_off;
   logic           copy_en;
   logic           busy;
   logic           copying;
   logic [VAW-1:0] cnt;

   if (DW < 1) begin : g_bad_dw
      $error("data width must be positive");
   end

   vdb_bus_decode #(
      .AW(AW), .VAW(VAW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
   ) i_decode (
      .bus_addr(bus_addr), .bus_mreq_n(bus_mreq_n), .bus_wr_n(bus_wr_n),
      .bus_rd_n(bus_rd_n), .dec(dec), .vram_off(cpu_off)
   );

   vdb_ctrl_regs #(
      .DW(DW), .LW(LW), .VBLANK_LINE(VBLANK_LINE), .LEAD_LINES(LEAD_LINES)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(dec.wr_act && dec.sel == SEL_CTRL),
      .wdata(bus_wdata), .scanline(scanline), .copying(copying),
      .copy_en(copy_en), .busy(busy)
   );

   vdb_copy_seq #(
      .VAW(VAW), .COPY_LEN(WIN_BYTES)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .vblank(vblank), .copy_en(copy_en),
      .copying(copying), .cnt(cnt)
   );

   vdb_ram_mux #(
      .DW(DW), .VAW(VAW)
   ) i_mux (
      .clk(clk), .rst_n(rst_n), .copying(copying), .cnt(cnt),
      .cpu_off(cpu_off),
      .cpu_vram_wr(dec.wr_act && dec.sel == SEL_VRAM),
      .cpu_wdata(bus_wdata), .back_rdata(back_rdata), .disp_addr(disp_addr),
      .back_addr(back_addr), .back_wdata(back_wdata), .back_we(back_we),
      .front_addr(front_addr), .front_wdata(front_wdata), .front_we(front_we),
      .front_rd_en(front_rd_en)
   );

   assign copy_in_progress = copying;

   always_comb begin
      bus_rdata = '0;
      if (dec.rd_act) begin
         case (dec.sel)
            SEL_VRAM:   bus_rdata = copying ? '0 : back_rdata;
            SEL_STATUS: bus_rdata = {{(DW-1){1'b0}}, busy};
            SEL_CTRL:   bus_rdata = {{(DW-1){1'b0}}, copy_en};
            default:    bus_rdata = '0;
         endcase
      end
   end

   AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mreq_n || bus_rd_n) |-> (bus_rdata == '0)); // R9

   AST_COPY_IGNORES_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_in_progress && !copy_en && front_addr != '0) |-> front_we); // R8

endmodule

// File: tb/test_vdb_copy_engine.sv
module test_vdb_copy_engine;
   localparam int CLK_P  = 10;
   localparam int TOTAL  = 4800;
   localparam int VBL    = 480;
   localparam int LEAD   = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata;
   logic        bus_mreq_n, bus_wr_n, bus_rd_n;
   logic        vblank;
   logic [9:0]  scanline;
   logic [12:0] disp_addr;
   logic        copy_in_progress;
   logic [12:0] back_addr, front_addr;
   logic [7:0]  back_wdata, back_rdata, front_wdata;
   logic        back_we, front_we, front_rd_en;

   logic [7:0] back_ram  [TOTAL];
   logic [7:0] front_ram [TOTAL];
   logic [7:0] ref_back  [TOTAL];

   int checks = 0;
   int errors = 0;
   int run_len = 0;
   bit done = 0;

   // reference state
   bit m_cop = 0;
   int m_cnt = 0;
   bit m_en  = 1;
   bit m_vq  = 0;

   always #(CLK_P/2) clk = ~clk;

   vdb_copy_engine i_vdb_copy_engine (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_mreq_n(bus_mreq_n), .bus_wr_n(bus_wr_n),
      .bus_rd_n(bus_rd_n), .vblank(vblank), .scanline(scanline),
      .disp_addr(disp_addr), .copy_in_progress(copy_in_progress),
      .back_addr(back_addr), .back_wdata(back_wdata), .back_we(back_we),
      .back_rdata(back_rdata), .front_addr(front_addr),
      .front_wdata(front_wdata), .front_we(front_we), .front_rd_en(front_rd_en)
   );

   // behavioural RAMs
   assign back_rdata = back_ram[back_addr];
   always @(posedge clk) begin
      if (back_we)  back_ram[back_addr]   <= back_wdata;
      if (front_we) front_ram[front_addr] <= front_wdata;
   end

   initial begin
      for (int i = 0; i < TOTAL; i++) begin
         back_ram[i]  = 8'((i * 7 + 3) & 255);
         ref_back[i]  = 8'((i * 7 + 3) & 255);
         front_ram[i] = 8'h00;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit in_win(input logic [15:0] a);
      return a >= 16'h8000 && a < 16'h92C0;
   endfunction

   // reference model: state update at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cop = 0; m_cnt = 0; m_en = 1; m_vq = 0;
      end else begin
         bit start;
         bit wr;
         wr = !bus_mreq_n && !bus_wr_n;
         start = vblank && !m_vq && m_en && !m_cop;
         if (wr && in_win(bus_addr) && !m_cop) ref_back[bus_addr - 16'h8000] = bus_wdata;
         if (wr && bus_addr == 16'h92C1) m_en = (bus_wdata != 0);
         if (m_cop) begin
            if (m_cnt == TOTAL - 1) begin m_cop = 0; m_cnt = 0; end
            else m_cnt++;
         end else if (start) begin
            m_cop = 1; m_cnt = 0;
         end
         m_vq = vblank;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp_rd;
         bit busy;
         busy = (scanline >= VBL - LEAD && scanline < VBL) || m_cop;
         exp_rd = 0;
         if (!bus_mreq_n && !bus_rd_n) begin
            if (in_win(bus_addr)) exp_rd = m_cop ? 0 : ref_back[bus_addr - 16'h8000];
            else if (bus_addr == 16'h92C0) exp_rd = busy;
            else if (bus_addr == 16'h92C1) exp_rd = m_en;
         end
         check("R3", "copy_in_progress", copy_in_progress, m_cop);
         check("R3", "front_we", front_we, m_cop);
         check("R10", "front_rd_en", front_rd_en, !m_cop);
         check("R10", "front_addr", front_addr, m_cop ? m_cnt : disp_addr);
         check("R1", "back_we", back_we,
               !bus_mreq_n && !bus_wr_n && in_win(bus_addr) && !m_cop);
         check("R9", "bus_rdata", bus_rdata, exp_rd);
         if (m_cop) begin
            check("R3", "back_addr", back_addr, m_cnt);
            check("R3", "front_wdata", front_wdata, ref_back[m_cnt]);
         end
         if (copy_in_progress) run_len++;
      end
   end

   task automatic idle_bus();
      bus_mreq_n = 1; bus_wr_n = 1; bus_rd_n = 1;
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_mreq_n = 0; bus_wr_n = 0;
      @(posedge clk); #1;
      idle_bus();
   endtask

   task automatic cpu_read(input logic [15:0] a, input int exp, input string req);
      @(posedge clk); #1;
      bus_addr = a; bus_mreq_n = 0; bus_rd_n = 0;
      @(negedge clk);
      check(req, "read data", bus_rdata, exp);
      @(posedge clk); #1;
      idle_bus();
   endtask

   task automatic set_line(input int l);
      @(posedge clk); #1;
      scanline = 10'(l);
   endtask

   task automatic set_vblank(input bit v);
      @(posedge clk); #1;
      vblank = v;
   endtask

   task automatic wait_copy_end();
      int guard = 0;
      while (!copy_in_progress && guard < 50) begin @(negedge clk); guard++; end
      while (copy_in_progress) @(negedge clk);
   endtask

   task automatic compare_front(input string req);
      int bad = 0;
      for (int i = 0; i < TOTAL; i++) if (front_ram[i] !== ref_back[i]) bad++;
      check(req, "front buffer mismatches", bad, 0);
   endtask

   task automatic finish_sim();
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      rst_n = 0; bus_addr = 0; bus_wdata = 0; idle_bus();
      vblank = 0; scanline = 0; disp_addr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      check("R11", "copy_in_progress in reset", copy_in_progress, 0);
      check("R11", "front_we in reset", front_we, 0);
      check("R11", "back_we in reset", back_we, 0);
      @(posedge clk); #1; rst_n = 1;

      cpu_read(16'h92C1, 1, "R7");
      // R1 writes at window edges
      cpu_write(16'h8000, 8'hA5);
      cpu_read(16'h8000, 8'hA5, "R1");
      cpu_write(16'h92BF, 8'h3C);
      cpu_read(16'h92BF, 8'h3C, "R1");
      cpu_read(16'h8123, ref_back[16'h123], "R9");

      // R2 writes that must not land
      cpu_write(16'h7FFF, 8'h11);
      cpu_write(16'h92C0, 8'h22);
      @(posedge clk); #1;
      bus_addr = 16'h8001; bus_wdata = 8'h99; bus_mreq_n = 1; bus_wr_n = 0;
      @(negedge clk);
      check("R2", "back_we with mreq high", back_we, 0);
      @(posedge clk); #1; idle_bus();
      cpu_read(16'h8001, 8'h0A, "R2");
      cpu_read(16'h7FFF, 0, "R2");

      // R5 busy window edges
      set_line(475); cpu_read(16'h92C0, 0, "R5");
      set_line(476); cpu_read(16'h92C0, 1, "R5");
      set_line(479); cpu_read(16'h92C0, 1, "R5");
      set_line(480); cpu_read(16'h92C0, 0, "R5");

      // R10 display path
      @(posedge clk); #1; disp_addr = 13'd123;
      @(negedge clk);
      check("R10", "front_addr follows display", front_addr, 123);
      check("R10", "front_rd_en idle", front_rd_en, 1);

      // R3 first copy
      run_len = 0;
      set_vblank(1);
      @(posedge clk); @(negedge clk);
      check("R3", "copy starts after vblank rise", copy_in_progress, 1);
      wait_copy_end();
      check("R3", "copy length", run_len, TOTAL);
      compare_front("R3");
      set_vblank(0);

      // R6 disable
      cpu_write(16'h92C1, 8'h00);
      cpu_read(16'h92C1, 0, "R7");
      run_len = 0;
      set_vblank(1);
      repeat (20) @(negedge clk);
      check("R6", "no copy while disabled", run_len, 0);
      set_vblank(0);

      // R6 re-enable with a nonzero value
      cpu_write(16'h92C1, 8'h80);
      cpu_read(16'h92C1, 1, "R6");
      cpu_write(16'h8010, 8'h77);
      run_len = 0;
      set_vblank(1);
      @(posedge clk); @(negedge clk);
      check("R6", "copy after re-enable", copy_in_progress, 1);
      // R4 write during copy dropped, R9 read during copy
      cpu_write(16'h8002, 8'hEE);
      cpu_read(16'h8002, 0, "R9");
      cpu_read(16'h92C0, 1, "R5");
      @(negedge clk);
      check("R10", "front_rd_en during copy", front_rd_en, 0);
      // R8 clear enable mid copy
      cpu_write(16'h92C1, 8'h00);
      wait_copy_end();
      check("R8", "copy completes after disable", run_len, TOTAL);
      compare_front("R8");
      cpu_read(16'h8002, ref_back[2], "R4");
      check("R4", "reference byte unchanged", ref_back[2], 8'h11);
      cpu_read(16'h92C1, 0, "R7");
      set_vblank(0);
      repeat (4) @(posedge clk);
      finish_sim();
   end
endmodule